// File: doc/BRIEF.md
# Clock Loss Monitor and Failover

This block supervises the two clocks feeding a PLL's phase comparator: the reference input and the PLL's feedback clock. It also supervises the lock indication coming back from the PLL. It runs entirely on a trusted monitor clock that never stops. Each supervised clock is synchronized into that domain and its rising edges are counted over a fixed window of monitor cycles. A clock whose count in a window is below a programmable minimum is judged failed. A failure in PLL mode raises a sticky loss-of-clock flag, and a drop of lock after lock was held raises a sticky loss-of-lock flag.

Either kind of event can raise a reset request when its own enable is set. The block then holds the request for a minimum time and releases it only once the reference is running and the PLL reports lock. During the request the live flags and the failover choice are wiped. The cause of the reset is kept in two reset-status bits that only a power-on reset or a write-one clear removes. After a clock failure the block drives a source-select code to the clock switching cells: self-clocked PLL when the reference failed, reference bypass when the feedback failed. That choice holds until the next reset, even if the failed clock comes back. In external-clock mode, all loss supervision is inert and the select code reports the external source.

Top module: `clk_loss_guard`

## Requirements
- R1: In PLL mode (ext_mode low) with lol_rst_en high, a fall of the synchronized lock input after lock was held makes rst_req go high.
- R2: A lock-loss reset sets rsr_lol. During the reset, st_lol and st_lock_sticky read 0. rsr_lol stays 1 after the reset ends.
- R3: With ext_mode high, lock loss and clock loss raise no flag and no reset request, st_lock reads 0, and clk_sel reads 2'b11.
- R4: With mon_en low, a stopped supervised clock sets no loss-of-clock flag and changes neither clk_sel nor rst_req.
- R5: Rising edges of each supervised clock are counted over WIN_LEN monitor cycles. A clock fails only when its window count is below min_edges; a count at or above min_edges is no failure.
- R6: A clock failure with mon_en high in PLL mode sets st_loc. st_loc stays 1 after the clock recovers and is cleared only by a reset.
- R7: With loc_rst_en high, a clock failure makes rst_req go high and sets rsr_loc.
- R8: A reference failure sets clk_sel to 2'b01 (self-clocked). The code stays there after the reference recovers, until a reset.
- R9: A feedback failure sets clk_sel to 2'b10 (reference bypass). The code stays there after the feedback recovers, until a reset. During a reset clk_sel is 2'b00.
- R10: rst_req is high after power-on reset. In PLL mode it falls only after RST_HOLD cycles and only when the reference is judged running and lock is present.
- R11: rsr_clr[0] clears rsr_lol and rsr_clr[1] clears rsr_loc. A new cause in the same cycle wins over the clear.
- R12: st_lock follows the synchronized lock input in PLL mode. st_lock_sticky is set while lock is held outside reset and falls on a lock loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trusted monitor clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ref_clk_in | input | 1 | Supervised reference clock |
| fb_clk_in | input | 1 | Supervised PLL feedback clock |
| pll_lock_in | input | 1 | Lock indication from the PLL |
| mon_en | input | 1 | Loss-of-clock supervision enable |
| lol_rst_en | input | 1 | Reset on loss of lock enable |
| loc_rst_en | input | 1 | Reset on loss of clock enable |
| ext_mode | input | 1 | External-clock mode (supervision inert) |
| min_edges | input | CNT_W | Minimum rising edges per window |
| rsr_clr | input | 2 | Write-one clear of the reset-status bits (bit0 lol, bit1 loc) |
| rst_req | output | 1 | System reset request |
| clk_sel | output | 2 | 00 PLL, 01 self-clocked, 10 reference bypass, 11 external |
| st_lock | output | 1 | Live lock status |
| st_lock_sticky | output | 1 | Lock held since last loss or reset |
| st_lol | output | 1 | Sticky loss-of-lock flag |
| st_loc | output | 1 | Sticky loss-of-clock flag |
| rsr_lol | output | 1 | Reset caused by loss of lock |
| rsr_loc | output | 1 | Reset caused by loss of clock |

## Verification
The hardest situation to reach is a reset that cannot end: a clock failure forces reset while the reference itself is stopped. Here the release condition must keep the request high, and the failover latch must already be wiped. The bench reaches it by first latching a bypass choice from a feedback failure, then enabling reset on clock loss and halting the reference. It holds the reference stopped for several windows before restarting it. A behavioural model running alongside tracks window boundaries and the synchronizer delay, so every retrigger and release cycle is compared.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

   typedef enum logic [1:0] {
      SEL_PLL = 2'b00,
      SEL_SCM = 2'b01,
      SEL_REF = 2'b10,
      SEL_EXT = 2'b11
   } clk_src_e;

   localparam int NUM_MON = 2;
   localparam int MON_REF = 0;
   localparam int MON_FB  = 1;

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkmon_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/clkmon_window.sv
module clkmon_window #(
   parameter int WIN_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic win_last
);

   localparam int WIN_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

   generate
      if (WIN_LEN < 2) begin : g_bad_win
         $error("clkmon_window: WIN_LEN must be at least 2");
      end
   endgenerate

   logic [WIN_W-1:0] wcnt;

   assign win_last = (wcnt == WIN_W'(WIN_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wcnt <= '0;
      else if (win_last) wcnt <= '0;
      else               wcnt <= wcnt + WIN_W'(1);
   end

endmodule

// File: rtl/clkmon_meter.sv
module clkmon_meter #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_in,
   input  logic             win_last,
   input  logic [CNT_W-1:0] min_edges,
   output logic             slow
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("clkmon_meter: CNT_W must be at least 2");
      end
   endgenerate

   logic             lvl;
   logic             lvl_prev;
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (clk_in),
      .q     (lvl)
   );

   assign rise    = lvl & ~lvl_prev;
   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= 1'b0;
         cnt      <= '0;
         slow     <= 1'b0;
      end else begin
         lvl_prev <= lvl;
         if (win_last) begin
            slow <= (cnt_inc < min_edges);
            cnt  <= '0;
         end else begin
            cnt  <= cnt_inc;
         end
      end
   end

   // R5
   verdict_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(win_last) |-> $stable(slow));

endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
   import clkmon_pkg::*;
#(
   parameter int RST_HOLD = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ext_mode,
   input  logic     mon_en,
   input  logic     lol_rst_en,
   input  logic     loc_rst_en,
   input  logic     lock_s,
   input  logic     ref_slow,
   input  logic     fb_slow,
   input  logic [1:0] rsr_clr,
   output logic     in_rst,
   output clk_src_e fo,
   output logic     lock_sticky,
   output logic     lol_flag,
   output logic     loc_flag,
   output logic     rsr_lol,
   output logic     rsr_loc
);

   localparam int HOLD_W = $clog2(RST_HOLD + 1);

   generate
      if (RST_HOLD < 1) begin : g_bad_hold
         $error("clkmon_ctrl: RST_HOLD must be at least 1");
      end
   endgenerate

   logic [HOLD_W-1:0] hold;
   logic              loc_ev;
   logic              lol_ev;
   logic              trig_lol;
   logic              trig_loc;
   logic              exit_ok;

   assign loc_ev   = mon_en & ~ext_mode & (ref_slow | fb_slow) & ~in_rst;
   assign lol_ev   = ~ext_mode & lock_sticky & ~lock_s & ~in_rst;
   assign trig_lol = lol_ev & lol_rst_en;
   assign trig_loc = loc_ev & loc_rst_en;
   assign exit_ok  = ext_mode | (~ref_slow & lock_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_rst      <= 1'b1;
         hold        <= HOLD_W'(RST_HOLD);
         fo          <= SEL_PLL;
         lock_sticky <= 1'b0;
         lol_flag    <= 1'b0;
         loc_flag    <= 1'b0;
         rsr_lol     <= 1'b0;
         rsr_loc     <= 1'b0;
      end else begin
         rsr_lol <= trig_lol | (rsr_lol & ~rsr_clr[0]);
         rsr_loc <= trig_loc | (rsr_loc & ~rsr_clr[1]);
         if (in_rst) begin
            fo          <= SEL_PLL;
            lock_sticky <= 1'b0;
            lol_flag    <= 1'b0;
            loc_flag    <= 1'b0;
            if (hold != '0)   hold   <= hold - HOLD_W'(1);
            else if (exit_ok) in_rst <= 1'b0;
         end else begin
            lock_sticky <= lock_s & ~ext_mode;
            lol_flag    <= lol_flag | lol_ev;
            loc_flag    <= loc_flag | loc_ev;
            if (fo == SEL_PLL && loc_ev)
               fo <= ref_slow ? SEL_SCM : SEL_REF;
            if (trig_lol | trig_loc) begin
               in_rst <= 1'b1;
               hold   <= HOLD_W'(RST_HOLD);
            end
         end
      end
   end

   // R8 R9
   failover_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!in_rst) && $past(fo) != SEL_PLL) |-> fo == $past(fo));

   // R1 R7
   reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_rst) |-> (rsr_lol || rsr_loc));

   // R2
   flags_wiped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rst && $past(in_rst)) |-> (!lol_flag && !loc_flag && !lock_sticky));

   // R3
   ext_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ext_mode) |-> (!$rose(loc_flag) && !$rose(lol_flag)));

   // R10
   exit_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_rst) |-> ($past(ext_mode) || ($past(lock_s) && !$past(ref_slow))));

endmodule

// File: rtl/clk_loss_guard.sv
module clk_loss_guard
   import clkmon_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int WIN_LEN     = 32,
   parameter int RST_HOLD    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             ref_clk_in,
   input  logic             fb_clk_in,
   input  logic             pll_lock_in,
   input  logic             mon_en,
   input  logic             lol_rst_en,
   input  logic             loc_rst_en,
   input  logic             ext_mode,
   input  logic [CNT_W-1:0] min_edges,
   input  logic [1:0]       rsr_clr,
   output logic             rst_req,
   output logic [1:0]       clk_sel,
   output logic             st_lock,
   output logic             st_lock_sticky,
   output logic             st_lol,
   output logic             st_loc,
   output logic             rsr_lol,
   output logic             rsr_loc
);

   logic [NUM_MON-1:0] mon_in;
   logic [NUM_MON-1:0] mon_slow;
   logic               win_last;
   logic               lock_s;
   clk_src_e           fo;

   assign mon_in[MON_REF] = ref_clk_in;
   assign mon_in[MON_FB]  = fb_clk_in;

   clkmon_window #(.WIN_LEN(WIN_LEN)) u_win (
      .clk      (clk),
      .rst_n    (por_n),
      .win_last (win_last)
   );

   generate
      for (genvar i = 0; i < NUM_MON; i++) begin : g_meter
         clkmon_meter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_meter (
            .clk       (clk),
            .rst_n     (por_n),
            .clk_in    (mon_in[i]),
            .win_last  (win_last),
            .min_edges (min_edges),
            .slow      (mon_slow[i])
         );
      end
   endgenerate

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (pll_lock_in),
      .q     (lock_s)
   );

   clkmon_ctrl #(.RST_HOLD(RST_HOLD)) u_ctrl (
      .clk         (clk),
      .rst_n       (por_n),
      .ext_mode    (ext_mode),
      .mon_en      (mon_en),
      .lol_rst_en  (lol_rst_en),
      .loc_rst_en  (loc_rst_en),
      .lock_s      (lock_s),
      .ref_slow    (mon_slow[MON_REF]),
      .fb_slow     (mon_slow[MON_FB]),
      .rsr_clr     (rsr_clr),
      .in_rst      (rst_req),
      .fo          (fo),
      .lock_sticky (st_lock_sticky),
      .lol_flag    (st_lol),
      .loc_flag    (st_loc),
      .rsr_lol     (rsr_lol),
      .rsr_loc     (rsr_loc)
   );

   assign clk_sel = ext_mode ? SEL_EXT : fo;
   assign st_lock = lock_s & ~ext_mode;

   // R3
   ext_select_chk: assert property (@(posedge clk) disable iff (!por_n)
      (ext_mode && $past(ext_mode)) |-> (!st_lock && !$rose(rst_req)));

endmodule

// File: tb/clk_loss_guard_test.sv
module clk_loss_guard_test;

   localparam int CNT_W = 8;
   localparam int WIN   = 32;
   localparam int HOLD  = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por_n = 1'b0, ref_clk_in, fb_clk_in, pll_lock_in = 1'b0;
   logic mon_en = 1'b1, lol_rst_en = 1'b1, loc_rst_en = 1'b0, ext_mode = 1'b0;
   logic [CNT_W-1:0] min_edges = 8'd4;
   logic [1:0] rsr_clr = 2'b00;
   logic rst_req, st_lock, st_lock_sticky, st_lol, st_loc, rsr_lol, rsr_loc;
   logic [1:0] clk_sel;

   int checks = 0, errors = 0, ref_half = 2, fb_half = 2;
   bit done = 0;

   clk_loss_guard #(.CNT_W(CNT_W), .WIN_LEN(WIN), .RST_HOLD(HOLD), .SYNC_STAGES(2)) uut (
      .clk(clk), .por_n(por_n), .ref_clk_in(ref_clk_in), .fb_clk_in(fb_clk_in),
      .pll_lock_in(pll_lock_in), .mon_en(mon_en), .lol_rst_en(lol_rst_en),
      .loc_rst_en(loc_rst_en), .ext_mode(ext_mode), .min_edges(min_edges),
      .rsr_clr(rsr_clr), .rst_req(rst_req), .clk_sel(clk_sel), .st_lock(st_lock),
      .st_lock_sticky(st_lock_sticky), .st_lol(st_lol), .st_loc(st_loc),
      .rsr_lol(rsr_lol), .rsr_loc(rsr_loc));

   // supervised clock generators, toggled 2 ns after each monitor edge
   initial begin
      int rph = 0, fph = 0;
      ref_clk_in = 1'b0; fb_clk_in = 1'b0;
      forever begin
         @(posedge clk); #2;
         if (ref_half > 0) begin rph++; if (rph >= ref_half) begin rph = 0; ref_clk_in = ~ref_clk_in; end end
         if (fb_half > 0)  begin fph++; if (fph >= fb_half)  begin fph = 0; fb_clk_in  = ~fb_clk_in;  end end
      end
   end

   // behavioural reference model
   bit hr[$], hf[$], hl[$];
   int m_wc, m_cr, m_cf, m_hold;
   bit m_sr, m_sf, m_stk, m_lol, m_loc, m_inrst, m_rl, m_rc;
   int m_fo;

   function automatic int sat(int v);
      return (v > 255) ? 255 : v;
   endfunction

   task automatic model_reset();
      hr = {0, 0, 0}; hf = {0, 0, 0}; hl = {0, 0};
      m_wc = 0; m_cr = 0; m_cf = 0; m_hold = HOLD;
      m_sr = 0; m_sf = 0; m_stk = 0; m_lol = 0; m_loc = 0;
      m_inrst = 1; m_rl = 0; m_rc = 0; m_fo = 0;
   endtask

   always @(posedge clk) begin
      bit er, ef, lk, last, locev, lolev, tl, tc;
      if (!por_n) model_reset();
      else begin
         er = hr[1] && !hr[0];
         ef = hf[1] && !hf[0];
         lk = hl[0];
         last  = (m_wc == WIN - 1);
         locev = mon_en && !ext_mode && (m_sr || m_sf) && !m_inrst;
         lolev = !ext_mode && m_stk && !lk && !m_inrst;
         tl = lolev && lol_rst_en;
         tc = locev && loc_rst_en;
         m_rl = tl || (m_rl && !rsr_clr[0]);
         m_rc = tc || (m_rc && !rsr_clr[1]);
         if (m_inrst) begin
            m_fo = 0; m_stk = 0; m_lol = 0; m_loc = 0;
            if (m_hold > 0) m_hold--;
            else if (ext_mode || (!m_sr && lk)) m_inrst = 0;
         end else begin
            m_stk = lk && !ext_mode;
            m_lol = m_lol || lolev;
            m_loc = m_loc || locev;
            if (m_fo == 0 && locev) m_fo = m_sr ? 1 : 2;
            if (tl || tc) begin m_inrst = 1; m_hold = HOLD; end
         end
         if (last) begin
            m_sr = sat(m_cr + int'(er)) < int'(min_edges);
            m_sf = sat(m_cf + int'(ef)) < int'(min_edges);
            m_cr = 0; m_cf = 0; m_wc = 0;
         end else begin
            m_cr = sat(m_cr + int'(er));
            m_cf = sat(m_cf + int'(ef));
            m_wc++;
         end
         hr.push_back(ref_clk_in); void'(hr.pop_front());
         hf.push_back(fb_clk_in);  void'(hf.pop_front());
         hl.push_back(pll_lock_in); void'(hl.pop_front());
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (por_n && !done) begin
         chk("R10", "rst_req", rst_req, m_inrst);
         chk("R8/R9", "clk_sel", clk_sel, ext_mode ? 3 : m_fo);
         chk("R12", "st_lock", st_lock, hl[0] && !ext_mode);
         chk("R12", "st_lock_sticky", st_lock_sticky, m_stk);
         chk("R2", "st_lol", st_lol, m_lol);
         chk("R6", "st_loc", st_loc, m_loc);
         chk("R2", "rsr_lol", rsr_lol, m_rl);
         chk("R7", "rsr_loc", rsr_loc, m_rc);
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1; checks++; errors++;
         $display("FAIL watchdog all-R actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      por_n = 1'b1;
      step(1);
      chk("R10", "reset state rst_req", rst_req, 1);
      chk("R10", "reset state clk_sel", clk_sel, 0);
      step(60);
      chk("R10", "no lock keeps reset", rst_req, 1);
      pll_lock_in = 1'b1;
      step(12);
      chk("R10", "release after lock", rst_req, 0);
      chk("R12", "st_lock", st_lock, 1);
      chk("R12", "st_lock_sticky", st_lock_sticky, 1);

      // R4: supervision disabled
      mon_en = 1'b0; fb_half = 0;
      step(80);
      chk("R4", "st_loc with monitor off", st_loc, 0);
      chk("R4", "clk_sel with monitor off", clk_sel, 0);
      fb_half = 2;
      step(80);
      mon_en = 1'b1;

      // R1/R2: lock loss reset
      pll_lock_in = 1'b0;
      step(6);
      chk("R1", "rst_req on lock loss", rst_req, 1);
      chk("R2", "rsr_lol set", rsr_lol, 1);
      step(3);
      chk("R2", "st_lol wiped", st_lol, 0);
      chk("R2", "st_lock_sticky wiped", st_lock_sticky, 0);
      step(20);
      pll_lock_in = 1'b1;
      step(15);
      chk("R10", "release after relock", rst_req, 0);
      chk("R2", "rsr_lol survives", rsr_lol, 1);

      // R11: write-one clear
      rsr_clr = 2'b01; step(1); rsr_clr = 2'b00;
      step(2);
      chk("R11", "rsr_lol cleared", rsr_lol, 0);

      // R5: count at or above threshold is no failure
      loc_rst_en = 1'b1; fb_half = 3;
      step(100);
      chk("R5", "6-cycle feedback passes", st_loc, 0);
      chk("R5", "no reset on passing clock", rst_req, 0);
      fb_half = 6;
      step(80);
      chk("R7", "rsr_loc on slow feedback", rsr_loc, 1);
      fb_half = 2;
      step(100);
      chk("R10", "release after recovery", rst_req, 0);
      chk("R9", "clk_sel after reset", clk_sel, 0);
      loc_rst_en = 1'b0;
      rsr_clr = 2'b10; step(1); rsr_clr = 2'b00;
      step(2);
      chk("R11", "rsr_loc cleared", rsr_loc, 0);

      // R6/R9: feedback failure without reset
      fb_half = 0;
      step(80);
      chk("R6", "st_loc set", st_loc, 1);
      chk("R9", "bypass select", clk_sel, 2);
      chk("R6", "no reset when disabled", rst_req, 0);
      fb_half = 2;
      step(100);
      chk("R9", "bypass latched after recovery", clk_sel, 2);
      chk("R6", "st_loc stays", st_loc, 1);

      // R10/R7: reset held while the reference is stopped
      loc_rst_en = 1'b1; ref_half = 0;
      step(100);
      chk("R10", "reset held without reference", rst_req, 1);
      chk("R9", "select wiped in reset", clk_sel, 0);
      chk("R7", "rsr_loc on reference loss", rsr_loc, 1);
      ref_half = 2;
      step(100);
      chk("R10", "release once reference runs", rst_req, 0);

      // R8: reference failure selects self-clocked mode
      loc_rst_en = 1'b0; ref_half = 0;
      step(80);
      chk("R8", "self-clocked select", clk_sel, 1);
      ref_half = 2;
      step(100);
      chk("R8", "self-clocked latched", clk_sel, 1);

      // R3: external-clock mode
      por_n = 1'b0;
      step(2);
      ext_mode = 1'b1; pll_lock_in = 1'b0; ref_half = 0; fb_half = 0;
      loc_rst_en = 1'b1; lol_rst_en = 1'b1;
      por_n = 1'b1;
      step(100);
      chk("R3", "no reset in ext mode", rst_req, 0);
      chk("R3", "external select", clk_sel, 3);
      chk("R3", "no loc flag", st_loc, 0);
      pll_lock_in = 1'b1;
      step(5);
      chk("R3", "st_lock low in ext mode", st_lock, 0);
      pll_lock_in = 1'b0;
      step(10);
      chk("R3", "no lock-loss reset", rst_req, 0);
      chk("R3", "no lol flag", st_lol, 0);
      chk("R3", "no lol cause", rsr_lol, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule